// File: doc/BRIEF.md
# Word-Addressed Byte Access Unit

This block gives a processor whose memory path only moves whole words a way to work on bytes and on packed sub-word elements. It has three independent parts. An address stage turns a combined element pointer into the word address to load or store, plus the bit offset of the element inside that word. An extract stage picks one byte out of a loaded word using the two low bits of any byte pointer. An insert stage overwrites one byte of a destination word with the low byte of a source operand, at a lane held in a small selector register that software loads before the insert.

Reading a byte is one word load followed by one extract. Writing a byte is a word load, an insert into the loaded word, and a word store. The address stage and both data stages are combinational. Only the selector register holds state.

Top module: `wbx_byte_unit`

## Requirements
- R1: The element width code `elem_log2_i` gives elements of 2^n bits for n = 0..5 (1, 2, 4, 8, 16, 32 bits). Codes 6 and 7 act as code 5.
- R2: `word_addr_o` is `ptr_i` shifted right by (5 - n), with zeros shifted in. For bytes (n = 3) this is `ptr_i >> 2`.
- R3: `bit_off_o` equals i * 2^n, where the element index i is the low (5 - n) bits of `ptr_i`. For n = 5 it is 0.
- R4: `ext_result_o` holds, in bits 7:0, byte lane k of `ext_word_i`, where k = `ext_bptr_i[1:0]` and lane 0 is bits 7:0. Bits 31:8 are zero. Higher pointer bits have no effect.
- R5: The selector register reads as lane 0 after reset. Reset is synchronous and active high.
- R6: When `sel_we_i` is high at a rising clock edge, the selector takes `sel_wdata_i[1:0]` and ignores the other bits. When `sel_we_i` is low, the selector keeps its value.
- R7: `ins_result_o` equals `ins_dst_i` with byte lane s replaced by `ins_src_i[7:0]`, where s is the selector value. The other three lanes pass through unchanged.
- R8: An insert at lane s followed by an extract at lane s of that result returns the inserted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_i | input | 32 | Combined element pointer |
| elem_log2_i | input | 3 | log2 of the element width in bits |
| word_addr_o | output | 32 | Word address of the element |
| bit_off_o | output | 5 | Bit offset of the element within the word |
| ext_word_i | input | 32 | Word to extract a byte from |
| ext_bptr_i | input | 32 | Byte pointer; only bits 1:0 are used |
| ext_result_o | output | 32 | Extracted byte, zero extended |
| sel_we_i | input | 1 | Selector register write enable |
| sel_wdata_i | input | 32 | Selector write data; only bits 1:0 are kept |
| ins_dst_i | input | 32 | Destination word for insert |
| ins_src_i | input | 32 | Source operand; its bits 7:0 are inserted |
| ins_result_o | output | 32 | Destination word with one lane replaced |

## Verification
The selector register is the only internal state. A wrong value there shows up as the inserted byte landing in the wrong lane of `ins_result_o`. This is visible in the first cycle after the faulty write, or right after reset. A selector that drifts without a write changes `ins_result_o` while all inputs are held steady, so holding-value checks catch it one edge later. A fault in the address or extract logic has no stored component and shows up at once on `word_addr_o`, `bit_off_o` or `ext_result_o` for the pointer patterns that exercise it.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WLOG    = $clog2(WORD_W);
    localparam int OFF_W   = WLOG;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        EW_BIT1  = 3'd0,
        EW_BIT2  = 3'd1,
        EW_BIT4  = 3'd2,
        EW_BYTE  = 3'd3,
        EW_HALF  = 3'd4,
        EW_WORD  = 3'd5
    } elem_width_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic [WORD_W-1:0] word_addr;
        logic [OFF_W-1:0]  bit_off;
    } elem_loc_t;

    // Codes above the widest element fold onto whole-word elements.
    function automatic elem_width_e clamp_width(input logic [CODE_W-1:0] code);
        if (code > CODE_W'(EW_WORD))
            return EW_WORD;
        return elem_width_e'(code);
    endfunction

endpackage

// File: rtl/wbx_addr_gen.sv
module wbx_addr_gen
    import wbx_pkg::*;
#(
    parameter int PTR_W = WORD_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [CODE_W-1:0] code,
    output elem_loc_t         loc
);
    localparam int SH_W = $clog2(WLOG + 1);

    elem_width_e       ew;
    logic [SH_W-1:0]   idx_bits;
    logic [PTR_W-1:0]  idx_mask;
    logic [PTR_W-1:0]  idx;
    logic [OFF_W-1:0]  idx_low;

    always_comb begin
        ew       = clamp_width(code);
        idx_bits = SH_W'(WLOG) - SH_W'(ew);
        idx_mask = ~({PTR_W{1'b1}} << idx_bits);
        idx      = ptr & idx_mask;
        idx_low  = idx[OFF_W-1:0];
        loc.word_addr = WORD_W'(ptr >> idx_bits);
        loc.bit_off   = idx_low << ew;
    end

endmodule

// File: rtl/wbx_extract.sv
module wbx_extract
    import wbx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  lane_t             lane,
    output logic [WORD_W-1:0] result
);
    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_bytes[l] = word[l*BYTE_W +: BYTE_W];
    end

    assign result = WORD_W'(lane_bytes[lane]);

endmodule

// File: rtl/wbx_insert.sv
module wbx_insert
    import wbx_pkg::*;
(
    input  logic [WORD_W-1:0] dst,
    input  logic [BYTE_W-1:0] new_byte,
    input  lane_t             lane,
    output logic [WORD_W-1:0] result
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign result[l*BYTE_W +: BYTE_W] =
            (lane == LANE_W'(l)) ? new_byte : dst[l*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/wbx_sel_reg.sv
module wbx_sel_reg
    import wbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output lane_t             q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata[LANE_W-1:0];
    end

endmodule

// File: rtl/wbx_byte_unit.sv
module wbx_byte_unit
    import wbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ptr_i,
    input  logic [CODE_W-1:0] elem_log2_i,
    output logic [WORD_W-1:0] word_addr_o,
    output logic [OFF_W-1:0]  bit_off_o,
    input  logic [WORD_W-1:0] ext_word_i,
    input  logic [WORD_W-1:0] ext_bptr_i,
    output logic [WORD_W-1:0] ext_result_o,
    input  logic              sel_we_i,
    input  logic [WORD_W-1:0] sel_wdata_i,
    input  logic [WORD_W-1:0] ins_dst_i,
    input  logic [WORD_W-1:0] ins_src_i,
    output logic [WORD_W-1:0] ins_result_o
);
    elem_loc_t loc;
    lane_t     sel_q;

    wbx_addr_gen #(.PTR_W(WORD_W)) u_addr (
        .ptr  (ptr_i),
        .code (elem_log2_i),
        .loc  (loc)
    );

    assign word_addr_o = loc.word_addr;
    assign bit_off_o   = loc.bit_off;

    wbx_extract u_ext (
        .word   (ext_word_i),
        .lane   (ext_bptr_i[LANE_W-1:0]),
        .result (ext_result_o)
    );

    wbx_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .we    (sel_we_i),
        .wdata (sel_wdata_i),
        .q     (sel_q)
    );

    wbx_insert u_ins (
        .dst      (ins_dst_i),
        .new_byte (ins_src_i[BYTE_W-1:0]),
        .lane     (sel_q),
        .result   (ins_result_o)
    );

endmodule

// File: rtl/wbx_byte_unit_chk.sv
module wbx_byte_unit_chk
    import wbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] ptr_i,
    input  logic [CODE_W-1:0] elem_log2_i,
    input  logic [WORD_W-1:0] word_addr_o,
    input  logic [OFF_W-1:0]  bit_off_o,
    input  logic [WORD_W-1:0] ext_result_o,
    input  logic              sel_we_i,
    input  logic [WORD_W-1:0] sel_wdata_i,
    input  logic [WORD_W-1:0] ins_dst_i,
    input  logic [WORD_W-1:0] ins_src_i,
    input  logic [WORD_W-1:0] ins_result_o,
    input  lane_t             sel_q
);
    int unsigned n_eff;
    int unsigned sh;
    logic [WORD_W-1:0] rebuilt;

    always_comb begin
        n_eff   = (elem_log2_i > 3'd5) ? 5 : int'(elem_log2_i);
        sh      = WLOG - n_eff;
        rebuilt = (word_addr_o << sh) | (WORD_W'(bit_off_o) >> n_eff);
    end

    // R2, R3: word address and offset together recover the pointer
    p_ptr_rebuild_r2: assert property (@(posedge clk) disable iff (rst)
        rebuilt == ptr_i);

    // R3: offset is a whole number of elements
    p_off_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        (WORD_W'(bit_off_o) & ((WORD_W'(1) << n_eff) - 1)) == '0);

    // R4: only one byte can be returned
    p_ext_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ext_result_o[WORD_W-1:BYTE_W] == '0);

    // R5
    p_sel_reset_r5: assert property (@(posedge clk)
        rst |=> (sel_q == '0));

    // R6
    p_sel_load_r6: assert property (@(posedge clk) disable iff (rst)
        sel_we_i |=> (sel_q == $past(sel_wdata_i[LANE_W-1:0])));

    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_we_i |=> $stable(sel_q));

    // R7: the selected lane carries the source byte
    p_ins_lane_r7: assert property (@(posedge clk) disable iff (rst)
        ins_result_o[sel_q*BYTE_W +: BYTE_W] == ins_src_i[BYTE_W-1:0]);

    // R7: exactly the selected lane may differ from the destination
    p_ins_keep_r7: assert property (@(posedge clk) disable iff (rst)
        ((ins_result_o ^ ins_dst_i) &
         ~(WORD_W'({BYTE_W{1'b1}}) << (sel_q*BYTE_W))) == '0);

endmodule

bind wbx_byte_unit wbx_byte_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ptr_i        (ptr_i),
    .elem_log2_i  (elem_log2_i),
    .word_addr_o  (word_addr_o),
    .bit_off_o    (bit_off_o),
    .ext_result_o (ext_result_o),
    .sel_we_i     (sel_we_i),
    .sel_wdata_i  (sel_wdata_i),
    .ins_dst_i    (ins_dst_i),
    .ins_src_i    (ins_src_i),
    .ins_result_o (ins_result_o),
    .sel_q        (sel_q)
);

// File: tb/wbx_byte_unit_tb.sv
module wbx_byte_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ptr_i = '0;
    logic [2:0]  elem_log2_i = '0;
    logic [31:0] word_addr_o;
    logic [4:0]  bit_off_o;
    logic [31:0] ext_word_i = '0;
    logic [31:0] ext_bptr_i = '0;
    logic [31:0] ext_result_o;
    logic        sel_we_i = 1'b0;
    logic [31:0] sel_wdata_i = '0;
    logic [31:0] ins_dst_i = '0;
    logic [31:0] ins_src_i = '0;
    logic [31:0] ins_result_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbx_byte_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .ptr_i        (ptr_i),
        .elem_log2_i  (elem_log2_i),
        .word_addr_o  (word_addr_o),
        .bit_off_o    (bit_off_o),
        .ext_word_i   (ext_word_i),
        .ext_bptr_i   (ext_bptr_i),
        .ext_result_o (ext_result_o),
        .sel_we_i     (sel_we_i),
        .sel_wdata_i  (sel_wdata_i),
        .ins_dst_i    (ins_dst_i),
        .ins_src_i    (ins_src_i),
        .ins_result_o (ins_result_o)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write the selector at one rising edge; inputs move on the falling edge.
    task automatic write_sel(input logic [31:0] v);
        @(negedge clk);
        sel_we_i    = 1'b1;
        sel_wdata_i = v;
        @(negedge clk);
        sel_we_i    = 1'b0;
    endtask

    task automatic addr_case(input string req, input logic [2:0] code, input logic [31:0] p,
                             input logic [31:0] exp_wa, input logic [4:0] exp_off);
        @(negedge clk);
        elem_log2_i = code;
        ptr_i       = p;
        #1;
        check32({req, " word_addr"}, word_addr_o, exp_wa);
        check32({req, " bit_off"}, 32'(bit_off_o), 32'(exp_off));
    endtask

    task automatic test_reset_state();
        // R5: selector is lane 0, so insert lands in bits 7:0
        @(negedge clk);
        ins_dst_i = 32'h11223344;
        ins_src_i = 32'hFFFFFF5A;
        #1;
        check32("R5 reset lane", ins_result_o, 32'h1122335A);
    endtask

    task automatic test_addr_gen();
        addr_case("R1 R2 R3 n0", 3'd0, 32'h0001_2345, 32'h0000_091A, 5'd5);
        addr_case("R2 R3 n1",    3'd1, 32'h0000_003F, 32'h0000_0003, 5'd30);
        addr_case("R2 R3 n2",    3'd2, 32'h0000_0017, 32'h0000_0002, 5'd28);
        addr_case("R2 R3 byte",  3'd3, 32'h0000_1003, 32'h0000_0400, 5'd24);
        addr_case("R2 R3 byte high", 3'd3, 32'hFFFF_FFFE, 32'h3FFF_FFFF, 5'd16);
        addr_case("R2 R3 n4",    3'd4, 32'h0000_0007, 32'h0000_0003, 5'd16);
        addr_case("R2 R3 n5",    3'd5, 32'h0000_0ABC, 32'h0000_0ABC, 5'd0);
        addr_case("R1 code6",    3'd6, 32'h8000_0001, 32'h8000_0001, 5'd0);
        addr_case("R1 code7",    3'd7, 32'h0000_0ABC, 32'h0000_0ABC, 5'd0);
    endtask

    task automatic test_extract();
        logic [31:0] exp [4] = '{32'hD4, 32'hC3, 32'hB2, 32'hA1};
        @(negedge clk);
        ext_word_i = 32'hA1B2C3D4;
        for (int k = 0; k < 4; k++) begin
            ext_bptr_i = 32'h5550_0000 | 32'(k);
            #1;
            check32("R4 extract lane", ext_result_o, exp[k]);
        end
        ext_word_i = 32'h80FF_7F01;
        ext_bptr_i = 32'hFFFF_FFFE;
        #1;
        check32("R4 extract high ptr bits", ext_result_o, 32'h0000_00FF);
    endtask

    task automatic test_insert_lanes();
        logic [31:0] exp [4] = '{32'h1122335A, 32'h11225A44, 32'h115A3344, 32'h5A223344};
        for (int s = 0; s < 4; s++) begin
            write_sel(32'hFFFF_FFF0 | 32'(s));
            ins_dst_i = 32'h11223344;
            ins_src_i = 32'hFFFFFF5A;
            #1;
            check32("R6 R7 insert lane", ins_result_o, exp[s]);
        end
    endtask

    task automatic test_sel_hold();
        write_sel(32'h0000_0006);
        // R6: write data changes with enable low; lane must stay 2
        @(negedge clk);
        sel_wdata_i = 32'h0000_0001;
        @(negedge clk);
        sel_wdata_i = 32'h0000_0003;
        @(negedge clk);
        ins_dst_i = 32'h00000000;
        ins_src_i = 32'h000000C7;
        #1;
        check32("R6 hold with we low", ins_result_o, 32'h00C7_0000);
    endtask

    task automatic test_byte_store_load();
        logic [31:0] stored;
        // R8: byte store at lane 1, then read back through extract
        write_sel(32'h0000_0001);
        ins_dst_i = 32'hDEADBEEF;
        ins_src_i = 32'h0000_0042;
        #1;
        stored = ins_result_o;
        check32("R8 stored word", stored, 32'hDEAD42EF);
        ext_word_i = stored;
        ext_bptr_i = 32'h0000_1005;
        #1;
        check32("R8 load back", ext_result_o, 32'h0000_0042);
    endtask

    task automatic test_reset_again();
        write_sel(32'h0000_0003);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ins_dst_i = 32'hAAAAAAAA;
        ins_src_i = 32'h00000055;
        #1;
        check32("R5 reset clears lane", ins_result_o, 32'hAAAAAA55);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset_state();
        test_addr_gen();
        test_extract();
        test_insert_lanes();
        test_sel_hold();
        test_byte_store_load();
        test_reset_again();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule